// File: doc/BRIEF.md
# Slope-Justified Two-Level Duty-Cycle Scheduler

This block drives the level index of a multilevel inverter phase for one modulation period at a time. At a start strobe it takes a fixed-point reference, expressed in units of one level step, and the reference value from the previous period. It splits the reference into its whole part and its fractional part. It then holds the two neighbouring levels for durations chosen so that the period-average level matches the reference to within one clock tick.

The order of the two levels follows the slope of the reference. A rising reference places the lower level first and the upper level last. A falling or flat reference places the upper level first and the lower level last. Across a period boundary the output therefore continues from the level nearest the new reference, and never steps by two levels inside a period.

Slope estimation and the choice of period length happen upstream. This block only times the levels inside each period it is given. A `period_done` flag marks the final tick of each period, so the upstream controller can issue the next strobe in that same cycle and chain periods with no gap.

Top module: `duty_level_sched`

## Requirements
- R1: Over each accepted period of P ticks, the sum of the output level over its P cycles, multiplied by 2^FRAC_W, differs from the (clamped) reference multiplied by P by less than 2^FRAC_W. This means the mean level is within one tick of the reference.
- R2: The reference is unsigned, with the upper LVL_W bits as the whole level count and the lower FRAC_W bits as the fraction. The output level index counts level steps from 0. Inside a period, only the floor level and, for a nonzero fraction, the floor+1 level appear.
- R3: When the reference is strictly greater than the previous sample, the floor level is output first. The floor+1 level is output for the last x = floor(frac·P / 2^FRAC_W) cycles of the period.
- R4: When the reference is not greater than the previous sample (equal included), the floor+1 level is output for the first x cycles. The floor level is output for the remaining cycles.
- R5: A period contains at most one level change, and no cycle-to-cycle change inside a period exceeds one level.
- R6: A zero fraction, or an x that truncates to zero, gives the floor level for the whole period with no change.
- R7: A strobe is accepted only while idle or in the final cycle of a running period; a strobe in any other cycle is ignored and leaves the running period unchanged. The first period cycle is the cycle after the accepting clock edge.
- R8: `period_done` is high in exactly the P-th cycle of each accepted period and low at all other times.
- R9: A strobe with `period_ticks` equal to 0 is ignored: no period starts and the level holds.
- R10: After reset the level index is 0. While idle, the level holds its last value.
- R11: A reference whose whole part is at or above NUM_LEVELS-1 is treated as exactly NUM_LEVELS-1 with a zero fraction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Strobe requesting a new period |
| ref_sample | input | LVL_W+FRAC_W | Reference for the new period, in level steps |
| prev_sample | input | LVL_W+FRAC_W | Reference of the preceding period, for slope sign |
| period_ticks | input | TICK_W | Period length in clock ticks |
| level_idx | output | LVL_W | Current output level index |
| period_done | output | 1 | High in the final tick of a period |

## Verification
The bench builds the block with nine levels, six fraction bits and an eight-bit tick count. With these values, periods of 1 to 255 ticks are in reach, and small periods truncate a nonzero fraction to no commutation at all. Nine levels let a reference beyond the top level exercise the clamp. The six fraction bits give per-period averages coarse enough that the one-tick bound of R1 is checked against exact integer sums. Rising, falling and flat slopes, chained and isolated periods, mid-period strobes and zero-length requests are all driven at these sizes.

// File: rtl/duty_sched_pkg.sv
// Package: shared types for the duty-cycle level scheduler.
// Assumes nothing beyond IEEE 1800-2017.
package duty_sched_pkg;

    // Sequencer phase: idle, holding the first level, holding the second level
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2
    } sched_phase_e;

endpackage

// File: rtl/level_split.sv
// level_split: splits a fixed-point reference into floor level, ceil level
// and fractional part. References at or above the top level clamp to the top
// level with zero fraction. Purely combinational.
// Assumes NUM_LEVELS >= 2 and LVL_W wide enough to hold NUM_LEVELS-1.
module level_split #(
    parameter int NUM_LEVELS = 9,
    parameter int LVL_W      = 4,
    parameter int FRAC_W     = 6,
    localparam int REF_W     = LVL_W + FRAC_W
) (
    input  logic [REF_W-1:0]  ref_in,
    output logic [LVL_W-1:0]  lvl_lo,
    output logic [LVL_W-1:0]  lvl_hi,
    output logic [FRAC_W-1:0] frac
);

    localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(NUM_LEVELS - 1);

    logic [LVL_W-1:0]  whole;
    logic [FRAC_W-1:0] part;

    assign whole = ref_in[REF_W-1:FRAC_W];
    assign part  = ref_in[FRAC_W-1:0];

    // Clamp at the top level, otherwise floor plus one step if a fraction remains
    always_comb begin
        if (whole >= TOP_LVL) begin
            lvl_lo = TOP_LVL;
            lvl_hi = TOP_LVL;
            frac   = '0;
        end else begin
            lvl_lo = whole;
            frac   = part;
            lvl_hi = (part != '0) ? whole + 1'b1 : whole;
        end
    end

endmodule

// File: rtl/commute_calc.sv
// commute_calc: from the fraction, period length and slope sign, works out
// which level comes first, which comes second, and how many ticks the first
// one lasts. The upper-level tick count is frac*period truncated.
// Assumes period_in >= 1 when the result is used.
module commute_calc #(
    parameter int LVL_W  = 4,
    parameter int FRAC_W = 6,
    parameter int TICK_W = 8,
    localparam int REF_W  = LVL_W + FRAC_W,
    localparam int PROD_W = FRAC_W + TICK_W
) (
    input  logic [REF_W-1:0]  ref_in,
    input  logic [REF_W-1:0]  prev_in,
    input  logic [LVL_W-1:0]  lvl_lo,
    input  logic [LVL_W-1:0]  lvl_hi,
    input  logic [FRAC_W-1:0] frac,
    input  logic [TICK_W-1:0] period_in,
    output logic [LVL_W-1:0]  lvl_first,
    output logic [LVL_W-1:0]  lvl_second,
    output logic [TICK_W-1:0] first_ticks
);

    logic [PROD_W-1:0] prod;
    logic [TICK_W-1:0] hi_ticks;
    logic              rising;

    assign prod     = PROD_W'(frac) * PROD_W'(period_in);
    assign hi_ticks = prod[PROD_W-1:FRAC_W];
    assign rising   = (ref_in > prev_in);

    // Rising: lower level leads; otherwise the upper level leads
    always_comb begin
        if (rising) begin
            lvl_first   = lvl_lo;
            lvl_second  = lvl_hi;
            first_ticks = period_in - hi_ticks;
        end else begin
            lvl_first   = lvl_hi;
            lvl_second  = lvl_lo;
            first_ticks = hi_ticks;
        end
    end

endmodule

// File: rtl/period_seq.sv
// period_seq: runs one modulation period. Counts ticks, swaps from the first
// to the second level after first_ticks cycles, flags the last tick and
// accepts a new period only while idle or on that last tick.
// Assumes first_ticks <= period_in.
module period_seq #(
    parameter int LVL_W  = 4,
    parameter int TICK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [TICK_W-1:0] period_in,
    input  logic [LVL_W-1:0]  lvl_first,
    input  logic [LVL_W-1:0]  lvl_second,
    input  logic [TICK_W-1:0] first_ticks,
    output logic [LVL_W-1:0]  level_q,
    output logic              last_tick,
    output logic              running
);
    import duty_sched_pkg::*;

    sched_phase_e      phase_q;
    logic [TICK_W-1:0] cnt_q;
    logic [TICK_W-1:0] per_q;
    logic [TICK_W-1:0] swap_q;
    logic [LVL_W-1:0]  second_q;
    logic              accept;

    // Last tick of a running period and the strobe acceptance window
    assign running   = (phase_q != PH_IDLE);
    assign last_tick = running && (cnt_q == per_q - 1'b1);
    assign accept    = start && (period_in != '0) && (!running || last_tick);

    // Phase, tick counter and level register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            cnt_q    <= '0;
            per_q    <= '0;
            swap_q   <= '0;
            second_q <= '0;
            level_q  <= '0;
        end else if (accept) begin
            cnt_q    <= '0;
            per_q    <= period_in;
            swap_q   <= first_ticks;
            second_q <= lvl_second;
            if (first_ticks == '0) begin
                phase_q <= PH_SECOND;
                level_q <= lvl_second;
            end else begin
                phase_q <= PH_FIRST;
                level_q <= lvl_first;
            end
        end else if (last_tick) begin
            phase_q <= PH_IDLE;
        end else if (running) begin
            cnt_q <= cnt_q + 1'b1;
            if (phase_q == PH_FIRST && (cnt_q + 1'b1) == swap_q) begin
                phase_q <= PH_SECOND;
                level_q <= second_q;
            end
        end
    end

endmodule

// File: rtl/duty_level_sched.sv
// duty_level_sched: top of the slope-justified duty-cycle scheduler. Splits
// the reference into neighbouring levels, orders them by slope sign and
// times them over a period of period_ticks cycles.
// Assumes inputs are held stable in the cycle the strobe is high.
module duty_level_sched #(
    parameter int NUM_LEVELS = 81,
    parameter int FRAC_W     = 8,
    parameter int TICK_W     = 16,
    localparam int LVL_W     = $clog2(NUM_LEVELS),
    localparam int REF_W     = LVL_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [REF_W-1:0]  ref_sample,
    input  logic [REF_W-1:0]  prev_sample,
    input  logic [TICK_W-1:0] period_ticks,
    output logic [LVL_W-1:0]  level_idx,
    output logic              period_done
);

    logic [LVL_W-1:0]  lo_w, hi_w, first_w, second_w;
    logic [FRAC_W-1:0] frac_w;
    logic [TICK_W-1:0] first_ticks_w;
    logic              running_w;

    level_split #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W), .FRAC_W(FRAC_W)) u_split (
        .ref_in (ref_sample),
        .lvl_lo (lo_w),
        .lvl_hi (hi_w),
        .frac   (frac_w)
    );

    commute_calc #(.LVL_W(LVL_W), .FRAC_W(FRAC_W), .TICK_W(TICK_W)) u_calc (
        .ref_in      (ref_sample),
        .prev_in     (prev_sample),
        .lvl_lo      (lo_w),
        .lvl_hi      (hi_w),
        .frac        (frac_w),
        .period_in   (period_ticks),
        .lvl_first   (first_w),
        .lvl_second  (second_w),
        .first_ticks (first_ticks_w)
    );

    period_seq #(.LVL_W(LVL_W), .TICK_W(TICK_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .period_in   (period_ticks),
        .lvl_first   (first_w),
        .lvl_second  (second_w),
        .first_ticks (first_ticks_w),
        .level_q     (level_idx),
        .last_tick   (period_done),
        .running     (running_w)
    );

endmodule

// File: rtl/duty_level_sched_chk.sv
// duty_level_sched_chk: temporal checks on the scheduler, bound to the top.
module duty_level_sched_chk #(
    parameter int LVL_W  = 4,
    parameter int TICK_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [TICK_W-1:0] period_ticks,
    input logic [LVL_W-1:0]  level_idx,
    input logic              period_done,
    input logic              running
);

    logic             accepted;
    logic             fresh_q;
    logic [LVL_W-1:0] lvl_d;
    logic [1:0]       chg_q;

    assign accepted = start && (period_ticks != '0) && (!running || period_done);

    // Count level changes inside the current period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fresh_q <= 1'b0;
            lvl_d   <= '0;
            chg_q   <= '0;
        end else begin
            fresh_q <= accepted;
            lvl_d   <= level_idx;
            if (accepted)
                chg_q <= '0;
            else if (running && !fresh_q && level_idx != lvl_d && chg_q != 2'd3)
                chg_q <= chg_q + 1'b1;
        end
    end

    assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !period_done) |=>
            ((level_idx == $past(level_idx)) ||
             (level_idx == $past(level_idx) + 1'b1) ||
             (level_idx + 1'b1 == $past(level_idx))));

    assert_one_commutation_R5: assert property (@(posedge clk) disable iff (!rst_n)
        chg_q <= 2'd1);

    assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !period_done) |=> running);

    assert_done_running_R8: assert property (@(posedge clk) disable iff (!rst_n)
        period_done |-> running);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !start) |=> $stable(level_idx));

endmodule

bind duty_level_sched duty_level_sched_chk #(.LVL_W(LVL_W), .TICK_W(TICK_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .period_ticks (period_ticks),
    .level_idx    (level_idx),
    .period_done  (period_done),
    .running      (running_w)
);

// File: tb/duty_level_sched_bench.sv
module duty_level_sched_bench;
    localparam int NL = 9;
    localparam int FW = 6;
    localparam int TW = 8;
    localparam int LW = $clog2(NL);
    localparam int RW = LW + FW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [RW-1:0] ref_sample = '0;
    logic [RW-1:0] prev_sample = '0;
    logic [TW-1:0] period_ticks = '0;
    logic [LW-1:0] level_idx;
    logic          period_done;

    always #4 clk = ~clk;   // 125 MHz

    duty_level_sched #(.NUM_LEVELS(NL), .FRAC_W(FW), .TICK_W(TW)) u_duty_level_sched (
        .clk(clk), .rst_n(rst_n), .start(start), .ref_sample(ref_sample),
        .prev_sample(prev_sample), .period_ticks(period_ticks),
        .level_idx(level_idx), .period_done(period_done)
    );

    typedef struct {
        int sum; int first; int chg; int scaled_ref; int per; string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    logic exp_acc = 1'b0;
    logic acc_seen = 1'b0;
    bit   inper = 1'b0;
    int   acc_sum, first_lv, prev_lv, chg_n;
    bit   done_flag = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Driver: waits for an accept window, drives the strobe, pushes the expectation
    task automatic run_period(input int r, input int p, input int per, input string tag);
        exp_t e;
        int whole, fr, lo, x;
        @(negedge clk);
        while (inper && !period_done) @(negedge clk);
        whole = r >> FW;
        fr    = r % (1 << FW);
        if (whole >= NL - 1) begin whole = NL - 1; fr = 0; end
        lo = whole;
        x  = (fr * per) >> FW;
        e.sum   = lo * per + x;
        e.first = (r > p) ? lo : ((x > 0) ? lo + 1 : lo);
        e.chg   = (x > 0) ? 1 : 0;
        e.scaled_ref = (whole << FW) + fr;
        e.per   = per;
        e.tag   = tag;
        exp_q.push_back(e);
        ref_sample = RW'(r); prev_sample = RW'(p); period_ticks = TW'(per);
        start = 1'b1; exp_acc = 1'b1;
        @(negedge clk);
        start = 1'b0; exp_acc = 1'b0;
    endtask

    always @(posedge clk) acc_seen <= start && exp_acc;

    // Monitor: integrates the level over each period and compares at period end
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            if (acc_seen) begin
                acc_sum = 0; chg_n = 0; first_lv = int'(level_idx);
                prev_lv = int'(level_idx); inper = 1'b1;
            end else if (inper && int'(level_idx) != prev_lv) begin
                chg_n++;
            end
            prev_lv = int'(level_idx);
            if (inper) acc_sum += int'(level_idx);
            if (period_done) begin
                if (!inper || exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected period_done", 1, 0);
                end else begin
                    exp_t e;
                    int err;
                    e = exp_q.pop_front();
                    err = (acc_sum << FW) - e.scaled_ref * e.per;
                    if (err < 0) err = -err;
                    check(err < (1 << FW), {"R1 mean within one tick ", e.tag}, err, 0);
                    check(acc_sum == e.sum, {"R2 R11 level sum ", e.tag}, acc_sum, e.sum);
                    check(first_lv == e.first, {"R3 R4 leading level ", e.tag}, first_lv, e.first);
                    check(chg_n == e.chg, {"R5 R6 commutations ", e.tag}, chg_n, e.chg);
                end
                inper = 1'b0;
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog
    initial begin
        #(8 * 50000);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(level_idx == '0, "R10 reset level", int'(level_idx), 0);
        check(period_done == 1'b0, "R8 reset done low", int'(period_done), 0);

        // R3 rising, frac 0.25 of 16 ticks -> 4 upper ticks at the end
        run_period((2 << FW) + 16, (1 << FW), 16, "rise");
        // R4 falling, same reference
        run_period((2 << FW) + 16, (3 << FW), 16, "fall");
        // R4 flat slope takes the falling order
        run_period((5 << FW) + 40, (5 << FW) + 40, 20, "flat");
        // R6 zero fraction
        run_period(4 << FW, 1 << FW, 12, "zero frac");
        // R6 fraction truncating to zero over 3 ticks
        run_period((3 << FW) + 10, (6 << FW), 3, "trunc");
        // one-tick period
        run_period((1 << FW) + 63, 0, 1, "one tick");
        // R11 clamp above top level
        run_period((NL << FW) + 5, 0, 9, "clamp");
        // floor level 0, long period, back-to-back chain (R7)
        run_period(33, 50, 255, "low fall");
        run_period(50, 33, 200, "low rise");

        // R7: strobe mid-period is ignored
        run_period((6 << FW) + 32, (7 << FW), 40, "ignored host");
        repeat (10) @(negedge clk);
        ref_sample = RW'(1 << FW); prev_sample = '0; period_ticks = TW'(5);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (inper) @(negedge clk);

        // R10: idle holds the last level (falling, lower level last = 6)
        repeat (4) @(negedge clk);
        check(level_idx == LW'(6), "R10 idle hold", int'(level_idx), 6);

        // R9: zero-length period ignored
        ref_sample = RW'(2 << FW); prev_sample = '0; period_ticks = '0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        held = 1;
        repeat (6) begin
            @(negedge clk);
            if (period_done || level_idx != LW'(6)) held = 0;
        end
        check(held == 1, "R9 zero period ignored", held, 1);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R8 every period completed", exp_q.size(), 0);
        finish_run();
    end
endmodule